// File: doc/BRIEF.md
# TMDS Word Boundary Aligner

A 1:10 deserializer on a TMDS lane produces 10-bit raw words, but the bit at which each word starts is arbitrary. This block finds the real symbol boundary and delivers correctly framed 10-bit symbols to the decoder that follows it. Each cycle it places the current raw word above the previous one to form a 20-bit window. It tests every 10-bit slice of that window against the four TMDS control tokens in parallel, and it picks the lowest offset that hits.

A candidate offset becomes the locked boundary only after it has carried a control token on a configurable number of token-bearing words in a row. From then on a shifter extracts the symbol at that offset, and the symbol passes through one output register. The aligned flag is raised at the same time. If the locked offset carries no token for a configurable number of consecutive words, the flag drops and the hunt starts again from nothing. The deserializer itself is never slipped, so the raw stream continues without interruption.

Top module: `tmds_word_aligner`

## Requirements
- R1: Bit 0 of each raw word is the earliest received bit. The window is {raw_word, previous raw_word}. Slice k (k = 0..10) is window bits k+9 down to k, and `bit_offset` reports the k in use, never a value above 10.
- R2: Exactly these four 10-bit values count as control tokens: 1101010100, 0010101011, 0101010100, 1010101011. Each of them refreshes a held lock.
- R3: When several slices match in one word, the hunt takes the lowest k. With a correctly framed stream that also fills slice 10, offset 0 is reported, not 10.
- R4: While hunting, a word whose lowest matching offset equals the current candidate extends the streak. Any other matching offset restarts the streak at 1 with that offset, and words with no match leave the streak unchanged. Lock is taken on the word where the streak reaches LOCK_COUNT.
- R5: `bit_offset` takes the candidate's value on the locking edge. It stays unchanged while locked and after a loss, until the next lock.
- R6: While locked, the lock is dropped on the word that completes MISS_LIMIT consecutive words with no token at the locked offset. The streak is then cleared and the hunt restarts.
- R7: While `aligned_valid` is 1, `aligned_word` equals the slice at `bit_offset` of the window seen one clock earlier. `aligned_valid` rises one clock after the locking edge and falls one clock after the dropping edge.
- R8: While `aligned_valid` is 0, `aligned_word` is all zeros.
- R9: A synchronous low on `rst_n` clears `aligned_valid`, `aligned_word`, `bit_offset`, the stored previous word and all hunt state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock of the deserializer |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_word | input | 10 | Raw deserializer word, bit 0 received first |
| aligned_word | output | 10 | Framed symbol, one register after the slice selection |
| aligned_valid | output | 1 | High while a boundary is locked |
| bit_offset | output | 4 | Offset of the slice in use (0..10) |

## Verification
The assertions assume that `raw_word` is a continuous serial stream cut into words. The window they rebuild from delayed copies of the input is then the same window the block sees, and a real control token can appear only at the true boundary and, for offset 0, at offset 10. The stimulus keeps to this. It builds one bit stream per phase from symbols, re-cuts it at each of the ten phases, and places zero symbols before each token run. With the token values used, neither a window that straddles a zero-to-token edge nor a repeated-token window can imitate a token at the wrong offset, so every expected lock, loss and relock word can be predicted exactly.

// File: rtl/tmds_align_pkg.sv
// Shared constants, control token test and state type for the TMDS word aligner.
// Assumes 10-bit TMDS symbols sent least-significant bit first.
package tmds_align_pkg;

    localparam int SYM_W   = 10;
    localparam int WIN_W   = 2 * SYM_W;
    localparam int NUM_OFF = SYM_W + 1;
    localparam int OFF_W   = $clog2(NUM_OFF);

    localparam logic [SYM_W-1:0] CTRL_TOK_0 = 10'b1101010100;
    localparam logic [SYM_W-1:0] CTRL_TOK_1 = 10'b0010101011;
    localparam logic [SYM_W-1:0] CTRL_TOK_2 = 10'b0101010100;
    localparam logic [SYM_W-1:0] CTRL_TOK_3 = 10'b1010101011;

    // True when a symbol equals one of the four control tokens.
    function automatic logic is_ctrl_token(input logic [SYM_W-1:0] sym);
        return (sym == CTRL_TOK_0) || (sym == CTRL_TOK_1) ||
               (sym == CTRL_TOK_2) || (sym == CTRL_TOK_3);
    endfunction

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/tmds_slice_match.sv
// Compares every 10-bit slice of the 20-bit window against the control tokens.
// Assumes window = {current word, previous word}; purely combinational.
module tmds_slice_match
    import tmds_align_pkg::*;
(
    input  logic [WIN_W-1:0]   window,
    output logic [NUM_OFF-1:0] hit_vec
);

    // One comparator per bit offset.
    generate
        for (genvar k = 0; k < NUM_OFF; k++) begin : g_slice
            assign hit_vec[k] = is_ctrl_token(window[k+SYM_W-1:k]);
        end
    endgenerate

endmodule

// File: rtl/tmds_first_hit.sv
// Priority encoder: reports whether any offset matched and the lowest one that did.
// Assumes hit_vec bit k stands for offset k; purely combinational.
module tmds_first_hit
    import tmds_align_pkg::*;
(
    input  logic [NUM_OFF-1:0] hit_vec,
    output logic               any_hit,
    output logic [OFF_W-1:0]   first_idx
);

    // Scan from the top down so the lowest set offset is the last one written.
    always_comb begin
        any_hit   = |hit_vec;
        first_idx = '0;
        for (int k = NUM_OFF - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                first_idx = OFF_W'(k);
            end
        end
    end

endmodule

// File: rtl/tmds_lock_ctrl.sv
// Hunt and lock state machine for the word boundary.
// Hunting: builds a streak of token words on one lowest offset; locks at LOCK_COUNT.
// Locked: counts consecutive words without a token at the locked offset; drops at MISS_LIMIT.
// Assumes LOCK_COUNT >= 1 and MISS_LIMIT >= 1.
module tmds_lock_ctrl
    import tmds_align_pkg::*;
#(
    parameter int LOCK_COUNT = 4,
    parameter int MISS_LIMIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OFF-1:0] hit_vec,
    input  logic               any_hit,
    input  logic [OFF_W-1:0]   first_idx,
    output logic               locked,
    output logic [OFF_W-1:0]   lock_off
);

    localparam int CNT_W  = $clog2(LOCK_COUNT + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0]  LOCK_TGT  = CNT_W'(LOCK_COUNT);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    lock_state_e       state_q, state_d;
    logic [OFF_W-1:0]  cand_q, cand_d;
    logic [OFF_W-1:0]  off_q, off_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic [CNT_W-1:0]  streak;
    logic              hit_at_lock;

    // Token present at the currently locked offset.
    assign hit_at_lock = |(hit_vec & (NUM_OFF'(1) << off_q));

    // Streak length if the current word matches.
    assign streak = ((cnt_q != '0) && (first_idx == cand_q)) ? cnt_q + CNT_W'(1) : CNT_W'(1);

    // Next-state decision for hunting and locked operation.
    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        off_d   = off_q;
        cnt_d   = cnt_q;
        miss_d  = miss_q;
        case (state_q)
            ST_HUNT: begin
                if (any_hit) begin
                    if (streak == LOCK_TGT) begin
                        state_d = ST_LOCKED;
                        off_d   = first_idx;
                        cnt_d   = '0;
                        miss_d  = '0;
                    end else begin
                        cand_d = first_idx;
                        cnt_d  = streak;
                    end
                end
            end
            ST_LOCKED: begin
                if (hit_at_lock) begin
                    miss_d = '0;
                end else if (miss_q == MISS_LAST) begin
                    state_d = ST_HUNT;
                    miss_d  = '0;
                    cnt_d   = '0;
                end else begin
                    miss_d = miss_q + MISS_W'(1);
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cand_q  <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            off_q   <= off_d;
            cnt_q   <= cnt_d;
            miss_q  <= miss_d;
        end
    end

    assign locked   = (state_q == ST_LOCKED);
    assign lock_off = off_q;

endmodule

// File: rtl/tmds_word_aligner.sv
// Top of the TMDS word boundary aligner.
// Keeps the previous raw word, searches all 11 offsets of the 20-bit window in
// parallel, locks a boundary and registers the selected slice once.
// Assumes raw_word holds consecutive deserializer words, bit 0 received first.
module tmds_word_aligner
    import tmds_align_pkg::*;
#(
    parameter int LOCK_COUNT = 4,
    parameter int MISS_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] raw_word,
    output logic [SYM_W-1:0] aligned_word,
    output logic             aligned_valid,
    output logic [OFF_W-1:0] bit_offset
);

    logic [SYM_W-1:0]   prev_q;
    logic [WIN_W-1:0]   window;
    logic [WIN_W-1:0]   shifted;
    logic [NUM_OFF-1:0] hit_vec;
    logic               any_hit;
    logic [OFF_W-1:0]   first_idx;
    logic               locked;
    logic [OFF_W-1:0]   lock_off;
    logic [SYM_W-1:0]   word_q;
    logic               valid_q;

    // Holds the previous raw word for the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= raw_word;
        end
    end

    assign window = {raw_word, prev_q};

    tmds_slice_match u_match (
        .window  (window),
        .hit_vec (hit_vec)
    );

    tmds_first_hit u_first (
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .first_idx (first_idx)
    );

    tmds_lock_ctrl #(
        .LOCK_COUNT (LOCK_COUNT),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .first_idx (first_idx),
        .locked    (locked),
        .lock_off  (lock_off)
    );

    // Slice selection at the locked offset.
    assign shifted = window >> lock_off;

    // Output stage: register the selected slice, zero while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            word_q  <= locked ? shifted[SYM_W-1:0] : '0;
            valid_q <= locked;
        end
    end

    assign aligned_word  = word_q;
    assign aligned_valid = valid_q;
    assign bit_offset    = lock_off;

endmodule

// File: rtl/tmds_word_aligner_chk.sv
// Assertion checker for tmds_word_aligner, attached by bind.
// Rebuilds the input window from its own delayed copies of raw_word.
module tmds_word_aligner_chk
    import tmds_align_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SYM_W-1:0] raw_word,
    input logic [SYM_W-1:0] aligned_word,
    input logic             aligned_valid,
    input logic [OFF_W-1:0] bit_offset
);

    logic [SYM_W-1:0] r0, r1, r2;

    // Input history: r0 is the word of the previous edge, r2 three edges back.
    always_ff @(posedge clk) begin
        r0 <= raw_word;
        r1 <= r0;
        r2 <= r1;
    end

    function automatic logic [SYM_W-1:0] slice_at(input logic [WIN_W-1:0] w,
                                                  input logic [OFF_W-1:0] off);
        logic [WIN_W-1:0] t;
        t = w >> off;
        return t[SYM_W-1:0];
    endfunction

    p_offset_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_offset <= OFF_W'(SYM_W));

    p_idle_word_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned_valid |-> (aligned_word == '0));

    p_word_from_slice_r7: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_valid |-> (aligned_word == slice_at({r0, r1}, bit_offset)));

    p_offset_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_valid && $past(aligned_valid)) |-> $stable(bit_offset));

    p_lock_on_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned_valid) |-> is_ctrl_token(slice_at({r1, r2}, bit_offset)));

    p_loss_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aligned_valid) |-> !is_ctrl_token(slice_at({r1, r2}, bit_offset)));

endmodule

bind tmds_word_aligner tmds_word_aligner_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .raw_word      (raw_word),
    .aligned_word  (aligned_word),
    .aligned_valid (aligned_valid),
    .bit_offset    (bit_offset)
);

// File: tb/tmds_word_aligner_tb_top.sv
// Sweeps all ten deserializer phases over one symbol stream and checks the
// lock timing, loss, relock, framed output and offset on every word.
module tmds_word_aligner_tb_top;

    localparam int LOCKN = 4;
    localparam int MISSN = 12;
    localparam int NSYM  = 82;
    localparam int NWORD = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] raw_word = '0;
    logic [9:0] aligned_word;
    logic       aligned_valid;
    logic [3:0] bit_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [9:0] sym [NSYM];

    always #2 clk = ~clk;

    tmds_word_aligner #(
        .LOCK_COUNT (LOCKN),
        .MISS_LIMIT (MISSN)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .raw_word      (raw_word),
        .aligned_word  (aligned_word),
        .aligned_valid (aligned_valid),
        .bit_offset    (bit_offset)
    );

    function automatic logic [9:0] tok(input int i);
        case (i)
            0: return 10'b1101010100;
            1: return 10'b0010101011;
            2: return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic bit is_tok(input logic [9:0] v);
        return (v == tok(0)) || (v == tok(1)) || (v == tok(2)) || (v == tok(3));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Symbol stream: zeros, token run, data with sparse tokens, zero gap, token run, data.
    task automatic build_stream(input int p);
        for (int i = 0; i < NSYM; i++) begin
            logic [9:0] d;
            d = 10'((i * 181 + p * 7 + 93) % 1024);
            if (is_tok(d)) d = d ^ 10'h001;
            if (i < 2)                  sym[i] = '0;
            else if (i < 10)            sym[i] = tok(0);
            else if (i == 20)           sym[i] = tok(1);
            else if (i == 31)           sym[i] = tok(2);
            else if (i == 42)           sym[i] = tok(3);
            else if (i == 53)           sym[i] = tok(0);
            else if (i < 54)            sym[i] = d;
            else if (i < 68)            sym[i] = '0;
            else if (i < 76)            sym[i] = tok(0);
            else if (i < 80)            sym[i] = d;
            else                        sym[i] = '0;
        end
    endtask

    // Raw word n at phase p: stream bits 10n+p .. 10n+p+9, bit 0 first.
    function automatic logic [9:0] raw_at(input int n, input int p);
        logic [9:0] w;
        for (int j = 0; j < 10; j++) begin
            int idx;
            idx = 10 * n + p + j;
            w[j] = sym[idx / 10][idx % 10];
        end
        return w;
    endfunction

    task automatic run_phase(input int p);
        int exp_off;
        exp_off = (p == 0) ? 0 : 10 - p;
        build_stream(p);
        @(negedge clk);
        rst_n = 1'b0;
        raw_word = '0;
        repeat (2) @(posedge clk);
        #1;
        chk(aligned_valid == 1'b0, "R9", "reset valid", int'(aligned_valid), 0);
        chk(aligned_word == '0, "R9", "reset word", int'(aligned_word), 0);
        chk(bit_offset == '0, "R9", "reset offset", int'(bit_offset), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < NWORD; n++) begin
            int  s;
            bit  ev;
            string rq;
            @(negedge clk);
            raw_word = raw_at(n, p);
            @(posedge clk);
            #1;
            s  = n - ((p == 0) ? 1 : 0);
            ev = ((s >= 2 + LOCKN) && (s <= 53 + MISSN)) || (s >= 68 + LOCKN);
            if (s < 10)       rq = "R4";
            else if (s < 54)  rq = "R2";
            else              rq = "R6";
            chk(aligned_valid == ev, rq, $sformatf("valid phase %0d word %0d", p, n),
                int'(aligned_valid), int'(ev));
            if (ev) begin
                chk(aligned_word == sym[s], "R7", $sformatf("R1 framed word phase %0d word %0d", p, n),
                    int'(aligned_word), int'(sym[s]));
            end else begin
                chk(aligned_word == '0, "R8", $sformatf("idle word phase %0d word %0d", p, n),
                    int'(aligned_word), 0);
            end
            if (s >= 1 + LOCKN) begin
                chk(int'(bit_offset) == exp_off, (p == 0) ? "R3" : "R5",
                    $sformatf("offset phase %0d word %0d", p, n), int'(bit_offset), exp_off);
            end else begin
                chk(bit_offset == '0, "R5", $sformatf("offset before lock phase %0d word %0d", p, n),
                    int'(bit_offset), 0);
            end
        end
    endtask

    initial begin
        for (int p = 0; p < 10; p++) begin
            run_phase(p);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule